// File: doc/BRIEF.md
# Quarter-Rate Complex Mixer with Fused 2x Decimation

This block turns a stream of real intermediate-frequency samples into baseband in-phase and quadrature samples when the carrier sits at exactly one quarter of the sample rate. At that ratio the local oscillator only takes the values +1, 0 and -1. Mixing therefore needs no multiplier and no oscillator: each sample is passed through, negated or dropped. Even-indexed samples carry the I component and odd-indexed samples carry the Q component. Dropping the zero-weighted half of each branch also performs a decimation by two, so no extra step is needed for it.

Each accepted beat carries `LANES` real samples in time order, with the earliest sample in the least significant slice of `in_data`. The beat produces `LANES/2` I samples and `LANES/2` Q samples, which are meant to feed a parallel polyphase low-pass filter directly. Negating the most negative code needs special handling. A parameter chooses between widening the output by one bit, which is exact, and keeping the input width and saturating, which clamps that one code. When `LANES/2` is odd, the four-sample oscillator period does not divide the beat. A one-bit phase register then tracks where the next beat starts, and it advances only on accepted beats.

Top module: `qmix_decim`

## Requirements
- R1: For sample index n counted from the first accepted beat after reset, output lane j of a beat takes input slice 2j (I) and slice 2j+1 (Q). The sign applied is + when (n mod 4) is 0 or 1 and - when it is 2 or 3. With `LANES` = 8 this gives I = (x1, -x3, x5, -x7) and Q = (x2, -x4, x6, -x8).
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: While `in_valid` is low, `i_data` and `q_data` hold their previous values.
- R4: With `MODE` = NEG_SAT (value 1), the output width equals the input width. Negating the most negative input code gives the largest positive code, and every other negation is exact.
- R5: With `MODE` = NEG_WIDEN (value 0), the output is one bit wider than the input. Every result equals the exact signed value, including the negated most negative code.
- R6: When `LANES/2` is odd, the sign pattern inverts on each accepted beat. Beats with `in_valid` low do not advance it. When `LANES/2` is even, the pattern is the same on every beat.
- R7: After an asynchronous active-low reset, `out_valid`, `i_data` and `q_data` are zero, and the sign pattern starts at phase 0.
- R8: Lanes whose sign is + pass the sign-extended input value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat is valid |
| in_data | input | LANES*IN_W | Real samples, earliest in bits [IN_W-1:0], two's complement |
| out_valid | output | 1 | Output beat is valid |
| i_data | output | (LANES/2)*OUT_W | I samples, lane 0 in the low slice |
| q_data | output | (LANES/2)*OUT_W | Q samples, lane 0 in the low slice |

## Verification
Two conditions are hard to reach from the ports. The first is the most negative code landing in a negated lane. The second is the beat-to-beat phase inversion, which only appears in a configuration where half the lane count is odd. The bench runs a 4-bit, eight-lane saturating instance next to a 4-bit, two-lane widening instance. Lane values step through every code, so each code reaches both negated and passed lanes. Idle beats are interleaved to show that holding and phase freeze happen together.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

  typedef enum logic {
    NEG_WIDEN = 1'b0,
    NEG_SAT   = 1'b1
  } neg_mode_e;

  // Output width: widening mode keeps one extra bit for -MIN.
  function automatic int out_width(input int in_w, input neg_mode_e m);
    return (m == NEG_SAT) ? in_w : in_w + 1;
  endfunction

  // True when the oscillator phase moves by half a period per beat.
  function automatic bit phase_steps(input int lanes);
    return ((lanes / 2) % 2) != 0;
  endfunction

endpackage

// File: rtl/qmix_phase.sv
module qmix_phase #(
  parameter int LANES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic flip
);
  localparam bit STEP = qmix_pkg::phase_steps(LANES);

  logic flip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flip_q <= 1'b0;
    else if (adv && STEP)  flip_q <= ~flip_q;
  end

  assign flip = flip_q;

  // R6: an idle beat never moves the phase
  a_r6_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(flip_q));

  if (STEP) begin : g_step
    // R6: each accepted beat inverts the pattern
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (flip_q != $past(flip_q)));
  end else begin : g_fixed
    // R6: pattern constant when the beat spans whole periods
    a_r6_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> !flip_q);
  end
endmodule

// File: rtl/qmix_lane.sv
module qmix_lane #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12,
  parameter bit SAT   = 1'b1
) (
  input  logic [IN_W-1:0]  x,
  input  logic             neg,
  output logic [OUT_W-1:0] y,
  output logic             clamped
);
  localparam logic [IN_W-1:0]  MIN_IN  = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};

  function automatic logic [OUT_W-1:0] sext(input logic [IN_W-1:0] v);
    return OUT_W'($signed(v));
  endfunction

  function automatic logic [OUT_W-1:0] negate(input logic [IN_W-1:0] v);
    if (SAT && v == MIN_IN) return MAX_OUT;
    return OUT_W'(-$signed(sext(v)));
  endfunction

  assign clamped = SAT && neg && (x == MIN_IN);
  assign y       = neg ? negate(x) : sext(x);
endmodule

// File: rtl/qmix_decim.sv
module qmix_decim #(
  parameter int                   LANES = 8,
  parameter int                   IN_W  = 12,
  parameter qmix_pkg::neg_mode_e  MODE  = qmix_pkg::NEG_SAT,
  localparam int                  OUT_W = qmix_pkg::out_width(IN_W, MODE),
  localparam int                  HALF  = LANES / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*IN_W-1:0] in_data,
  output logic                  out_valid,
  output logic [HALF*OUT_W-1:0] i_data,
  output logic [HALF*OUT_W-1:0] q_data
);
  localparam bit                SAT     = (MODE == qmix_pkg::NEG_SAT);
  localparam logic [IN_W-1:0]   MIN_IN  = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [OUT_W-1:0]  MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};

  // Named internal events for the assertions
  logic             beat_take;
  logic             flip;
  logic [HALF-1:0]  neg_lane;
  logic [HALF-1:0]  clamp_i, clamp_q;
  logic [IN_W-1:0]  x_i [HALF];
  logic [IN_W-1:0]  x_q [HALF];
  logic [OUT_W-1:0] mix_i [HALF];
  logic [OUT_W-1:0] mix_q [HALF];
  logic [OUT_W-1:0] reg_i [HALF];
  logic [OUT_W-1:0] reg_q [HALF];
  logic             vld_q;

  assign beat_take = in_valid;

  qmix_phase #(.LANES(LANES)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (beat_take),
    .flip (flip)
  );

  for (genvar j = 0; j < HALF; j++) begin : g_lane
    assign x_i[j]      = in_data[(2*j)*IN_W   +: IN_W];
    assign x_q[j]      = in_data[(2*j+1)*IN_W +: IN_W];
    // samples 2j and 2j+1 share a sign: index mod 4 is 2 or 3 when negated
    assign neg_lane[j] = flip ^ (j % 2 == 1);

    qmix_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .SAT(SAT)) u_i (
      .x(x_i[j]), .neg(neg_lane[j]), .y(mix_i[j]), .clamped(clamp_i[j])
    );
    qmix_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .SAT(SAT)) u_q (
      .x(x_q[j]), .neg(neg_lane[j]), .y(mix_q[j]), .clamped(clamp_q[j])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_i[j] <= '0;
        reg_q[j] <= '0;
      end else if (beat_take) begin
        reg_i[j] <= mix_i[j];
        reg_q[j] <= mix_q[j];
      end
    end

    assign i_data[j*OUT_W +: OUT_W] = reg_i[j];
    assign q_data[j*OUT_W +: OUT_W] = reg_q[j];

    // R1: a negated positive sample comes out negative
    a_r1_sign_i: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_take && neg_lane[j] && !x_i[j][IN_W-1] && x_i[j] != '0)
        |=> reg_i[j][OUT_W-1]);

    // R8: a passed lane keeps the sign of its input
    a_r8_pass_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_take && !neg_lane[j]) |=> (reg_q[j][OUT_W-1] == $past(x_q[j][IN_W-1])));

    if (SAT) begin : g_sat
      // R4: -MIN clamps to the largest positive code
      a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_take && neg_lane[j] && x_i[j] == MIN_IN) |=> (reg_i[j] == MAX_OUT));
    end else begin : g_wide
      // R5: widening mode never clamps
      a_r5_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_i[j] || clamp_q[j]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end
  assign out_valid = vld_q;

  // R2: one-cycle valid latency
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: idle beats hold the outputs
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(i_data) && $stable(q_data)));
endmodule

// File: tb/qmix_decim_test.sv
module qmix_decim_test;
  localparam int W  = 4;
  localparam int LA = 8;
  localparam int LB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              va, vb;
  logic [LA*W-1:0]   da;
  logic [LB*W-1:0]   db;
  logic              ova, ovb;
  logic [(LA/2)*W-1:0]     ia, qa;
  logic [(LB/2)*(W+1)-1:0] ib, qb;

  qmix_decim #(.LANES(LA), .IN_W(W), .MODE(qmix_pkg::NEG_SAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(va), .in_data(da),
    .out_valid(ova), .i_data(ia), .q_data(qa)
  );

  qmix_decim #(.LANES(LB), .IN_W(W), .MODE(qmix_pkg::NEG_WIDEN)) uut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(vb), .in_data(db),
    .out_valid(ovb), .i_data(ib), .q_data(qb)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ei_a[LA/2];
  int eq_a[LA/2];
  int ei_b, eq_b;
  bit ev;
  bit phase_b;
  bit done = 1'b0;

  function automatic int sv4(input logic [W-1:0] raw);
    return (raw >= 8) ? int'(raw) - 16 : int'(raw);
  endfunction

  function automatic int mixv(input int x, input bit neg, input bit sat);
    int r;
    r = neg ? -x : x;
    if (sat && r > 7) r = 7;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input bit v, input int seed);
    va = v;
    vb = v;
    for (int k = 0; k < LA; k++) da[k*W +: W] = W'((seed + 5*k) & 15);
    db[0 +: W] = W'(seed & 15);
    db[W +: W] = W'((seed ^ 9) & 15);
    if (v) begin
      for (int j = 0; j < LA/2; j++) begin
        ei_a[j] = mixv(sv4(da[(2*j)*W +: W]),   j % 2 == 1, 1'b1);
        eq_a[j] = mixv(sv4(da[(2*j+1)*W +: W]), j % 2 == 1, 1'b1);
      end
      ei_b = mixv(sv4(db[0 +: W]), phase_b, 1'b0);
      eq_b = mixv(sv4(db[W +: W]), phase_b, 1'b0);
      phase_b = ~phase_b;
    end
    ev = v;
    @(negedge clk);
    chk("R2 valid a", int'(ova), int'(ev));
    chk("R2 valid b", int'(ovb), int'(ev));
    for (int j = 0; j < LA/2; j++) begin
      if (!ev) begin
        chk("R3 hold I", int'($signed(ia[j*W +: W])), ei_a[j]);
      end else if (j % 2 == 1 && sv4(da[(2*j)*W +: W]) == -8 && seed >= 0) begin
        chk("R4 clamp I", int'($signed(ia[j*W +: W])), ei_a[j]);
      end else if (j % 2 == 0) begin
        chk("R8 pass I", int'($signed(ia[j*W +: W])), ei_a[j]);
      end else begin
        chk("R1 negate I", int'($signed(ia[j*W +: W])), ei_a[j]);
      end
      chk("R1 Q lane", int'($signed(qa[j*W +: W])), eq_a[j]);
    end
    chk("R5/R6 widen I", int'($signed(ib)), ei_b);
    chk("R5/R6 widen Q", int'($signed(qb)), eq_b);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    va = 1'b0; vb = 1'b0; da = '1; db = '1;
    phase_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R7: reset state
    chk("R7 valid", int'(ova) + int'(ovb), 0);
    chk("R7 i_data", int'(ia), 0);
    chk("R7 q_data", int'(qa), 0);
    chk("R7 b data", int'(ib) + int'(qb), 0);
    for (int j = 0; j < LA/2; j++) begin
      ei_a[j] = 0;
      eq_a[j] = 0;
    end
    ei_b = 0;
    eq_b = 0;
    rst_n = 1'b1;
    for (int s = 0; s < 96; s++) beat((s % 5) != 4, s);
    // back-to-back idle beats must not move the phase (R6)
    beat(1'b0, 3);
    beat(1'b0, 7);
    beat(1'b1, 8);
    beat(1'b1, 9);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule